// File: doc/BRIEF.md
# Amplifier Linearity Calibration Sequencer

This block tunes the linearity of an amplifier. It steps a capacitor tuning code through every value and scores each one. After each code change it waits a fixed settling time so the analog output can recover. It then collects a fixed-length frame of envelope-detector samples from an ADC. From that frame it computes the squared magnitude of one spectral bin, the bin where the third-order intermodulation product lands for a two-tone stimulus. The code with the smallest value wins, and that code is driven back onto the tuning output when the sweep ends.

A single recursive resonator computes the bin, so no full transform is needed. The whole design runs from one 51.2 MHz clock. With the default frame of 512 samples the bins are 100 kHz apart. The default target bin is 20, which is 2 MHz. The settling wait of 62 cycles is about 1.2 µs. A full sweep of 32 codes ends well inside a 485 µs budget.

Top module: `lin_cal_seq`

## Requirements
- R1: After synchronous reset, `tune_code`, `done`, `best_code` and `best_metric` are all zero.
- R2: When `start` is seen in idle, `tune_code` takes the values 0, 1, 2, … up to 31, in that order and each value once. Value 0 appears in the cycle after the start edge.
- R3: Samples are discarded in the 63 cycles that begin with the cycle in which a new `tune_code` value first appears, whatever `sample_valid` is. These are 1 apply cycle plus 62 settling cycles.
- R4: For each code, exactly 512 samples are accumulated, taken only in cycles where `sample_valid` is 1. Valid samples that arrive after the 512th, before the next code, are ignored.
- R5: Each sample is offset by −512 to give x. The state updates as s ← x + ⌊C·s1/2^14⌋ − s2, with s2 ← s1 and s1 ← s. The constant C is round(2·cos(2π·20/512)·2^14). The metric is s1² + s2² − ⌊C·s1/2^14⌋·s2, and a negative result is clamped to 0.
- R6: `best_code` is the code with the smallest metric. When metrics are equal the lower code is kept. `best_metric` is that code's metric.
- R7: `done` is high for exactly one cycle. When `sample_valid` is high every cycle, `done` is high in the cycle 32·577 = 18464 cycles after the start edge. This is within the 24832-cycle (485 µs) budget.
- R8: From the cycle after `done`, `tune_code` equals `best_code`. `best_code`, `best_metric` and `tune_code` then stay stable until the next `start`.
- R9: `start` has no effect while a sweep is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, 51.2 MHz |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a sweep when the block is idle |
| sample | input | 10 | Offset-binary ADC word from the envelope detector |
| sample_valid | input | 1 | Qualifies `sample` |
| tune_code | output | 5 | Capacitor-array control code |
| done | output | 1 | One-cycle pulse at the end of the sweep |
| best_code | output | 5 | Code with the lowest distortion metric |
| best_metric | output | 64 | Squared bin magnitude for `best_code` |

## Verification
A settle or frame count that is off by even one cycle puts a discarded or extra sample into the resonator. Because the bench drives full-scale junk during the discard window, every later metric changes, and the error shows at `best_metric` at the end of the sweep. A sequencing fault shows much sooner: a skipped or repeated code, or a restart on a stray `start`, appears at `tune_code` within one code period of 577 cycles. A fault in the minimum tracker, such as taking a tie or missing a lower value, shows only at `done`, as the wrong `best_code`.

// File: rtl/lin_cal_pkg.sv
package lin_cal_pkg;

    localparam int SAMPLE_W  = 10;
    localparam int CODE_W    = 5;
    localparam int ACC_W     = 32;
    localparam int METRIC_W  = 2 * ACC_W;
    localparam int COEF_W    = 18;
    localparam int COEF_FRAC = 14;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_APPLY,
        ST_SETTLE,
        ST_CAPTURE,
        ST_COMPUTE,
        ST_COMPARE,
        ST_DONE
    } cal_state_e;

    typedef struct packed {
        logic [CODE_W-1:0]   code;
        logic [METRIC_W-1:0] metric;
    } cand_t;

    // 2*cos(2*pi*bin/frame) in Q(COEF_FRAC), via a cosine series at elaboration
    function automatic int resonator_coef(int bin, int frame);
        real w, term, sum;
        w    = 2.0 * 3.141592653589793 * real'(bin) / real'(frame);
        term = 1.0;
        sum  = 1.0;
        for (int i = 1; i <= 20; i++) begin
            term = -term * w * w / real'((2 * i - 1) * (2 * i));
            sum  = sum + term;
        end
        return $rtoi(2.0 * sum * real'(1 << COEF_FRAC) + 0.5);
    endfunction

endpackage

// File: rtl/cal_timer.sv
module cal_timer #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    output logic             expire
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (tick && cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expire = tick && (cnt == CNT_W'(1));

    // R4
    cnt_nogrow_chk: assert property (@(posedge clk) disable iff (rst)
        !load |=> cnt <= $past(cnt));

endmodule

// File: rtl/goertzel_bin.sv
module goertzel_bin
    import lin_cal_pkg::*;
#(
    parameter int COEF = 31786
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                clr,
    input  logic                en,
    input  logic                calc,
    input  logic [SAMPLE_W-1:0] sample,
    output logic [METRIC_W-1:0] power
);
    localparam int PW    = ACC_W + COEF_W;
    localparam int QW    = 2 * ACC_W + 2;
    localparam int MID   = 1 << (SAMPLE_W - 1);
    localparam logic signed [COEF_W-1:0] COEF_S = COEF_W'(COEF);

    logic signed [ACC_W-1:0] s1, s2, s0, fb, x_ext;
    logic signed [PW-1:0]    prod;
    logic signed [QW-1:0]    pw;

    always_comb begin
        x_ext = ACC_W'($signed({1'b0, sample})) - ACC_W'(MID);
        prod  = PW'(COEF_S) * PW'(s1);
        fb    = ACC_W'(prod >>> COEF_FRAC);
        s0    = x_ext + fb - s2;
        pw    = QW'(s1) * QW'(s1) + QW'(s2) * QW'(s2) - QW'(fb) * QW'(s2);
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            s1 <= '0;
            s2 <= '0;
        end else if (en) begin
            s2 <= s1;
            s1 <= s0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            power <= '0;
        else if (calc)
            power <= pw[QW-1] ? '0 : pw[METRIC_W-1:0];
    end

    // R5
    power_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !calc |=> $stable(power));

endmodule

// File: rtl/min_tracker.sv
module min_tracker
    import lin_cal_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  clr,
    input  logic  upd,
    input  cand_t cand,
    output cand_t best
);
    logic have;
    logic take;

    assign take = upd && (!have || cand.metric < best.metric);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            best <= '0;
            have <= 1'b0;
        end else if (take) begin
            best <= cand;
            have <= 1'b1;
        end
    end

    // R6
    min_mono_chk: assert property (@(posedge clk) disable iff (rst)
        (upd && have && !clr) |=> best.metric <= $past(best.metric));

    // R6
    tie_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (upd && have && !clr && cand.metric == best.metric) |=> best.code == $past(best.code));

endmodule

// File: rtl/lin_cal_seq.sv
module lin_cal_seq
    import lin_cal_pkg::*;
#(
    parameter int FRAME_LEN  = 512,
    parameter int SETTLE_CYC = 62,
    parameter int TARGET_BIN = 20
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [SAMPLE_W-1:0] sample,
    input  logic                sample_valid,
    output logic [CODE_W-1:0]   tune_code,
    output logic                done,
    output logic [CODE_W-1:0]   best_code,
    output logic [METRIC_W-1:0] best_metric
);
    localparam int CNT_MAX = (FRAME_LEN > SETTLE_CYC) ? FRAME_LEN : SETTLE_CYC;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam int COEF    = resonator_coef(TARGET_BIN, FRAME_LEN);

    cal_state_e          state;
    logic [CODE_W-1:0]   code_r;
    logic                tmr_load, tmr_tick, tmr_expire;
    logic [CNT_W-1:0]    tmr_val;
    logic [METRIC_W-1:0] power;
    cand_t               cand, best;

    always_comb begin
        tmr_load = (state == ST_APPLY) || (state == ST_SETTLE && tmr_expire);
        tmr_val  = (state == ST_APPLY) ? CNT_W'(SETTLE_CYC) : CNT_W'(FRAME_LEN);
        tmr_tick = (state == ST_SETTLE) || (state == ST_CAPTURE && sample_valid);
    end

    cal_timer #(.CNT_W(CNT_W)) i_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .tick     (tmr_tick),
        .expire   (tmr_expire)
    );

    goertzel_bin #(.COEF(COEF)) i_bin (
        .clk    (clk),
        .rst    (rst),
        .clr    (state == ST_APPLY),
        .en     (state == ST_CAPTURE && sample_valid),
        .calc   (state == ST_COMPUTE),
        .sample (sample),
        .power  (power)
    );

    assign cand.code   = code_r;
    assign cand.metric = power;

    min_tracker i_min (
        .clk  (clk),
        .rst  (rst),
        .clr  (state == ST_IDLE && start),
        .upd  (state == ST_COMPARE),
        .cand (cand),
        .best (best)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            code_r <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (start) begin
                    code_r <= '0;
                    state  <= ST_APPLY;
                end
                ST_APPLY:   state <= ST_SETTLE;
                ST_SETTLE:  if (tmr_expire) state <= ST_CAPTURE;
                ST_CAPTURE: if (tmr_expire) state <= ST_COMPUTE;
                ST_COMPUTE: state <= ST_COMPARE;
                ST_COMPARE: begin
                    if (code_r == '1) begin
                        state <= ST_DONE;
                    end else begin
                        code_r <= code_r + 1'b1;
                        state  <= ST_APPLY;
                    end
                end
                ST_DONE: begin
                    code_r <= best.code;
                    state  <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign tune_code   = code_r;
    assign done        = (state == ST_DONE);
    assign best_code   = best.code;
    assign best_metric = best.metric;

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R2
    code_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SETTLE || state == ST_CAPTURE || state == ST_COMPUTE) |-> $stable(tune_code));

    // R2
    sweep_step_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_APPLY && $past(state) == ST_COMPARE) |-> tune_code == $past(tune_code) + 1'b1);

    // R8
    best_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && !start) |=> $stable(best_code) && $stable(best_metric));

endmodule

// File: tb/test_lin_cal_seq.sv
module test_lin_cal_seq;
    import lin_cal_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int FRAME      = 512;
    localparam int SETTLE     = 62;
    localparam int BIN        = 20;
    localparam int NCODE      = 32;
    localparam int DISCARD    = SETTLE + 1;
    localparam int RUN_CYC    = NCODE * (1 + SETTLE + FRAME + 2);
    localparam int BUDGET     = 24832;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                start = 1'b0;
    logic [SAMPLE_W-1:0] sample = '0;
    logic                sample_valid = 1'b0;
    logic [CODE_W-1:0]   tune_code;
    logic                done;
    logic [CODE_W-1:0]   best_code;
    logic [METRIC_W-1:0] best_metric;

    always #(CLK_PERIOD / 2) clk = ~clk;

    lin_cal_seq i_lin_cal_seq (
        .clk          (clk),
        .rst          (rst),
        .start        (start),
        .sample       (sample),
        .sample_valid (sample_valid),
        .tune_code    (tune_code),
        .done         (done),
        .best_code    (best_code),
        .best_metric  (best_metric)
    );

    typedef struct {
        int     code;
        longint metric;
        bit     timed;
    } exp_t;

    exp_t   exp_q[$];
    int     checks = 0;
    int     errors = 0;
    longint cyc_ctr = 0;
    longint start_at = 0;
    int     mode = 0;
    bit     gaps = 0;
    bit     arm = 0;
    bit     in_run = 0;
    bit     saw_done = 0;
    int     k = 0;
    int     jcnt = 0;
    int     prev_code = 0;
    int     sweep_n = 0;

    always @(posedge clk) cyc_ctr <= cyc_ctr + 1;

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int iabs(int v);
        return (v < 0) ? -v : v;
    endfunction

    function automatic int amp(int m, int code);
        case (m)
            0: return iabs(code - 13) + 1;
            1: return iabs(code - 22) + 2;
            2: return (code == 5 || code == 9) ? 1 : 3 + (code % 4);
            3: return 0;
            default: return 32 - code;
        endcase
    endfunction

    function automatic int sample_for(int m, int code, int j);
        return 512 + amp(m, code) * (((j * 37) % 64) - 32) / 4;
    endfunction

    function automatic longint ref_power(int m, int code);
        longint c, s0, s1, s2, fb, p;
        c  = longint'($rtoi(2.0 * $cos(2.0 * 3.141592653589793 * BIN / FRAME) * 16384.0 + 0.5));
        s1 = 0;
        s2 = 0;
        for (int j = 0; j < FRAME; j++) begin
            fb = (c * s1) >>> 14;
            s0 = longint'(sample_for(m, code, j) - 512) + fb - s2;
            s2 = s1;
            s1 = s0;
        end
        fb = (c * s1) >>> 14;
        p  = s1 * s1 + s2 * s2 - fb * s2;
        return (p < 0) ? 0 : p;
    endfunction

    // one bench cycle: drive inputs at the falling edge
    task automatic tick(bit do_start);
        @(negedge clk);
        if (done) in_run = 0;
        if (arm) begin
            check(tune_code == 0, "R2", "first code", tune_code, 0);
            k = 0; jcnt = 0; arm = 0; start_at = cyc_ctr; in_run = 1; sweep_n = 0;
        end else if (int'(tune_code) != prev_code) begin
            if (in_run) begin
                check(int'(tune_code) == prev_code + 1, "R2", "code step", tune_code, prev_code + 1);
                sweep_n++;
            end
            k = 0; jcnt = 0;
        end else begin
            k++;
        end
        prev_code = tune_code;
        start = do_start;
        if (k < DISCARD) begin
            sample_valid = 1'b1;
            sample = '1;
        end else if (gaps && (k % 5) == 2) begin
            sample_valid = 1'b0;
            sample = '1;
        end else begin
            sample_valid = 1'b1;
            sample = SAMPLE_W'(sample_for(mode, int'(tune_code), jcnt));
            jcnt++;
        end
    endtask

    task automatic run_cal(int m, bit g, bit poke);
        exp_t e;
        longint p;
        logic [CODE_W-1:0] hold_code;
        logic [METRIC_W-1:0] hold_metric;
        mode = m;
        gaps = g;
        e.code = 0;
        e.metric = ref_power(m, 0);
        e.timed = !g;
        for (int c = 1; c < NCODE; c++) begin
            p = ref_power(m, c);
            if (p < e.metric) begin
                e.code = c;
                e.metric = p;
            end
        end
        exp_q.push_back(e);
        saw_done = 0;
        tick(1'b1);
        arm = 1;
        tick(1'b0);
        while (!saw_done) begin
            // R9: stray start in the middle of the sweep
            tick(poke && (cyc_ctr - start_at) == 3000);
        end
        check(sweep_n == NCODE - 1, "R2", "code steps in sweep", sweep_n, NCODE - 1);
        tick(1'b0);
        hold_code = best_code;
        hold_metric = best_metric;
        for (int i = 0; i < 20; i++) tick(1'b0);
        check(best_code == hold_code, "R8", "best_code held", best_code, hold_code);
        check(best_metric == hold_metric, "R8", "best_metric held", best_metric, hold_metric);
        check(tune_code == hold_code, "R8", "tune_code held", tune_code, hold_code);
    endtask

    // scoreboard monitor
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            if (done === 1'b1) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R7", "unexpected done", 1, 0);
                end else begin
                    e = exp_q.pop_front();
                    check(int'(best_code) == e.code, "R6", "best_code", best_code, e.code);
                    check(longint'(best_metric) == e.metric, "R5", "best_metric", best_metric, e.metric);
                    check(cyc_ctr - start_at <= BUDGET, "R7", "within budget", cyc_ctr - start_at, BUDGET);
                    if (e.timed)
                        check(cyc_ctr - start_at == RUN_CYC, "R7", "done cycle", cyc_ctr - start_at, RUN_CYC);
                    @(negedge clk);
                    check(done == 1'b0, "R7", "done width", done, 0);
                    check(int'(tune_code) == e.code, "R8", "tune_code after done", tune_code, e.code);
                end
                saw_done = 1;
            end
        end
    end

    initial begin
        forever begin
            @(posedge clk);
            if (cyc_ctr > 190000) begin
                errors++;
                checks++;
                $display("FAIL R7 watchdog: actual %0d expected %0d", cyc_ctr, 190000);
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        check(tune_code == 0, "R1", "tune_code", tune_code, 0);
        check(done == 0, "R1", "done", done, 0);
        check(best_code == 0, "R1", "best_code", best_code, 0);
        check(best_metric == 0, "R1", "best_metric", best_metric, 0);
        prev_code = tune_code;
        run_cal(0, 1'b0, 1'b0);   // R3 R4 R5 R6: minimum in mid range
        run_cal(1, 1'b1, 1'b1);   // R4 gaps in valid, R9 stray start
        run_cal(2, 1'b0, 1'b0);   // R6 tie keeps the lower code
        run_cal(3, 1'b0, 1'b0);   // R6 all metrics equal -> code 0
        run_cal(4, 1'b0, 1'b0);   // R6 minimum at the last code
        check(exp_q.size() == 0, "R7", "pending results", exp_q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule